// File: doc/BRIEF.md
# Dual-Lane NOR Flash Command Sequencer

This block sits between a simple request port and a 32-bit synchronous memory bus built from two 16-bit NOR flash devices placed side by side, one per half-word. It accepts one request at a time and turns it into the flash command traffic it needs. The three requests are reading the identity codes, erasing a block and programming one word. Every command byte is sent in both halves of the bus word, so the two devices always step together.

For an erase or a program, the block first clears the status register and then sends the setup command and its argument. It then keeps issuing a status read and sampling the result until both halves report the ready bit. A programmable poll limit stops this loop if the devices never report ready. When the loop ends, the block returns both devices to array-read mode and forms the result. A program is also read back and compared with the written word. Identify reads the manufacturer word and the device word and returns them with the response.

The bus has a fixed read latency of one cycle. Read data for a read issued in one cycle is valid during the next cycle.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset the block has `req_ready` high and `rsp_valid`, `bus_we` and `bus_re` low, and it issues no bus access until a request is accepted.
- R2: Identify is opcode 0. It writes 0x00900090 to word 0, reads word 0 and then word 1, and writes 0x00FF00FF to word 0. The response has result 0, `rsp_mfr` equal to the word 0 data and `rsp_dev` equal to the word 1 data.
- R3: Erase is opcode 1. It writes, all at `req_addr` and in this order, clear-status 0x00500050, erase-setup 0x00200020 and erase-confirm 0x00D000D0.
- R4: Program is opcode 2. It writes, all at `req_addr` and in this order, clear-status 0x00500050, program-setup 0x00400040 and the word `req_data`.
- R5: After the start of an erase or program, each poll writes 0x00700070 at the address and then reads it. Polling continues until bits 7 and 23 of the read word are both set. A word with only one of the two set counts as busy.
- R6: When polling ends, the next bus write is 0x00FF00FF at the same address, and it comes before the response.
- R7: An erase returns result 1 if bit 5 or bit 21 of the final status is set, and result 0 otherwise. Error bits left over from earlier operations are cleared by the clear-status write and do not count.
- R8: A program reads the address once more after the read-array write. It returns result 2 if bit 4 or bit 20 of the final status is set, or if that read differs from `req_data`. Otherwise it returns result 0.
- R9: With L = max(`poll_limit`, 1), if the L-th poll is still busy, the block stops polling, writes 0x00FF00FF and returns result 3. It skips the program read-back in this case.
- R10: If the devices first report ready on the L-th poll itself, ready takes precedence and no timeout is reported.
- R11: The result codes are 0 ok, 1 erase error, 2 program error and 3 timeout. Opcode 3 is accepted and answered with result 0, and it causes no bus access.
- R12: `req_ready` is low from acceptance until the response. `rsp_valid` is a single-cycle pulse.
- R13: `bus_we` and `bus_re` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted when both are high |
| req_op | input | 2 | 0 identify, 1 erase, 2 program, 3 no-op |
| req_addr | input | AW | Target word address |
| req_data | input | 32 | Word to program |
| poll_limit | input | TW | Largest number of status polls, sampled at acceptance |
| rsp_valid | output | 1 | Response pulse |
| rsp_result | output | 2 | Result code |
| rsp_mfr | output | 32 | Manufacturer word from identify |
| rsp_dev | output | 32 | Device word from identify |
| bus_we | output | 1 | Bus write strobe |
| bus_re | output | 1 | Bus read strobe |
| bus_addr | output | AW | Bus word address |
| bus_wdata | output | 32 | Bus write data |
| bus_rdata | input | 32 | Bus read data, valid the cycle after `bus_re` |

## Verification
Device-ready and poll-limit expiry can occur on the same status sample. This is provoked by setting the model's busy count so that both halves first report ready on exactly the last permitted poll, and the run is judged by a zero result and a poll count equal to the limit. One more poll of busy turns the same case into a timeout, which is also checked. A program whose final status error and read-back mismatch occur together must still report one program error.

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq #(
  parameter int AW = 20,
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [31:0]   req_data,
  input  logic [TW-1:0] poll_limit,
  output logic          rsp_valid,
  output logic [1:0]    rsp_result,
  output logic [31:0]   rsp_mfr,
  output logic [31:0]   rsp_dev,
  output logic          bus_we,
  output logic          bus_re,
  output logic [AW-1:0] bus_addr,
  output logic [31:0]   bus_wdata,
  input  logic [31:0]   bus_rdata
);

  localparam logic [31:0] C_ARRAY  = 32'h00FF00FF;
  localparam logic [31:0] C_IDENT  = 32'h00900090;
  localparam logic [31:0] C_ESETUP = 32'h00200020;
  localparam logic [31:0] C_ECONF  = 32'h00D000D0;
  localparam logic [31:0] C_PSETUP = 32'h00400040;
  localparam logic [31:0] C_STATUS = 32'h00700070;
  localparam logic [31:0] C_CLEAR  = 32'h00500050;
  localparam logic [31:0] M_READY  = 32'h00800080;
  localparam logic [31:0] M_EERR   = 32'h00200020;
  localparam logic [31:0] M_PERR   = 32'h00100010;

  localparam logic [1:0] OP_ID = 2'd0, OP_ER = 2'd1, OP_PG = 2'd2;
  localparam logic [1:0] RES_OK = 2'd0, RES_EERR = 2'd1, RES_PERR = 2'd2, RES_TMO = 2'd3;

  typedef enum logic [3:0] {
    S_IDLE, S_IDCMD, S_IDRD0, S_IDRD1, S_IDCAP,
    S_CLR, S_SETUP, S_ARG, S_PCMD, S_PRD, S_PCHK,
    S_FIN, S_VRD, S_VCHK, S_RESP
  } st_t;

  st_t            st;
  logic [1:0]     op_q, res_q;
  logic [AW-1:0]  addr_q;
  logic [31:0]    data_q, mfr_q, dev_q;
  logic [TW-1:0]  lim_q;
  logic [TW:0]    cnt_q;

  logic        rdy, expire;
  logic [TW:0] cnt_nxt;

  assign cnt_nxt = cnt_q + {{TW{1'b0}}, 1'b1};
  assign rdy     = (bus_rdata & M_READY) == M_READY;
  assign expire  = cnt_nxt >= {1'b0, lim_q};

  assign req_ready  = (st == S_IDLE);
  assign rsp_valid  = (st == S_RESP);
  assign rsp_result = res_q;
  assign rsp_mfr    = mfr_q;
  assign rsp_dev    = dev_q;

  assign bus_we = st inside {S_IDCMD, S_CLR, S_SETUP, S_ARG, S_PCMD, S_FIN};
  assign bus_re = st inside {S_IDRD0, S_IDRD1, S_PRD, S_VRD};
  assign bus_addr = (st == S_IDRD1) ? {{(AW-1){1'b0}}, 1'b1} : addr_q;

  always_comb begin
    case (st)
      S_IDCMD: bus_wdata = C_IDENT;
      S_CLR:   bus_wdata = C_CLEAR;
      S_SETUP: bus_wdata = (op_q == OP_ER) ? C_ESETUP : C_PSETUP;
      S_ARG:   bus_wdata = (op_q == OP_ER) ? C_ECONF : data_q;
      S_PCMD:  bus_wdata = C_STATUS;
      S_FIN:   bus_wdata = C_ARRAY;
      default: bus_wdata = 32'h0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      op_q   <= OP_ID;
      res_q  <= RES_OK;
      addr_q <= '0;
      data_q <= '0;
      mfr_q  <= '0;
      dev_q  <= '0;
      lim_q  <= '0;
      cnt_q  <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          op_q   <= req_op;
          addr_q <= (req_op == OP_ID) ? '0 : req_addr;
          data_q <= req_data;
          lim_q  <= poll_limit;
          res_q  <= RES_OK;
          case (req_op)
            OP_ID:        st <= S_IDCMD;
            OP_ER, OP_PG: st <= S_CLR;
            default:      st <= S_RESP;
          endcase
        end
        S_IDCMD: st <= S_IDRD0;
        S_IDRD0: st <= S_IDRD1;
        S_IDRD1: begin mfr_q <= bus_rdata; st <= S_IDCAP; end
        S_IDCAP: begin dev_q <= bus_rdata; st <= S_FIN; end
        S_CLR:   st <= S_SETUP;
        S_SETUP: st <= S_ARG;
        S_ARG:   begin cnt_q <= '0; st <= S_PCMD; end
        S_PCMD:  st <= S_PRD;
        S_PRD:   st <= S_PCHK;
        S_PCHK: begin
          if (rdy) begin
            if (op_q == OP_ER && (bus_rdata & M_EERR) != 32'h0) res_q <= RES_EERR;
            if (op_q == OP_PG && (bus_rdata & M_PERR) != 32'h0) res_q <= RES_PERR;
            st <= S_FIN;
          end else if (expire) begin
            res_q <= RES_TMO;
            st    <= S_FIN;
          end else begin
            cnt_q <= cnt_nxt;
            st    <= S_PCMD;
          end
        end
        S_FIN:   st <= (op_q == OP_PG && res_q != RES_TMO) ? S_VRD : S_RESP;
        S_VRD:   st <= S_VCHK;
        S_VCHK: begin
          if (bus_rdata != data_q) res_q <= RES_PERR;
          st <= S_RESP;
        end
        S_RESP:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [31:0] last_wr_q;
  always_ff @(posedge clk) begin
    if (!rst_n) last_wr_q <= '0;
    else if (bus_we) last_wr_q <= bus_wdata;
  end

  assert_rw_exclusive_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_re));

  assert_rsp_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_accept_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_repoll_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PCHK && !rdy && !expire) |=> (bus_we && bus_wdata == C_STATUS));

  assert_array_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && op_q != 2'd3) |-> (last_wr_q == C_ARRAY));

  assert_ready_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PCHK && rdy) |=> (res_q != RES_TMO));

endmodule

// File: tb/tb_nor_cmd_seq.sv
`timescale 1ns/1ps
module tb_nor_cmd_seq;
  localparam int AW = 20;
  localparam int TW = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, req_valid, req_ready, rsp_valid, bus_we, bus_re;
  logic [1:0] req_op, rsp_result;
  logic [AW-1:0] req_addr, bus_addr;
  logic [31:0] req_data, rsp_mfr, rsp_dev, bus_wdata, bus_rdata;
  logic [TW-1:0] poll_limit;

  nor_cmd_seq #(.AW(AW), .TW(TW)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_data(req_data), .poll_limit(poll_limit),
    .rsp_valid(rsp_valid), .rsp_result(rsp_result), .rsp_mfr(rsp_mfr), .rsp_dev(rsp_dev),
    .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  int checks = 0;
  int fails = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // flash pair model
  logic [31:0] mem [16];
  int busy_left, busy_cfg;
  logic [31:0] busy_pat, err_cfg, flip_cfg, stale_cfg, sr_err, op_err, mfr_val, dev_val;
  logic [1:0] mode;
  logic pend_e, pend_p;
  logic [AW-1:0] wa [2048];
  logic [31:0]   wd [2048];
  logic [AW-1:0] ra [2048];
  int wn = 0;
  int rn = 0;
  int both_cnt = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mode <= 2'd0; pend_e <= 1'b0; pend_p <= 1'b0; busy_left <= 0;
      sr_err <= 32'h0; op_err <= 32'h0; bus_rdata <= 32'h0;
      for (int i = 0; i < 16; i++) mem[i] <= 32'h0;
    end else begin
      if (req_valid && req_ready) sr_err <= stale_cfg;
      if (bus_we && bus_re) both_cnt <= both_cnt + 1;
      if (bus_we) begin
        wa[wn % 2048] <= bus_addr;
        wd[wn % 2048] <= bus_wdata;
        wn <= wn + 1;
        if (pend_p) begin
          mem[bus_addr[3:0]] <= bus_wdata ^ flip_cfg;
          busy_left <= busy_cfg; mode <= 2'd1; pend_p <= 1'b0; op_err <= err_cfg;
        end else begin
          case (bus_wdata)
            32'h00FF00FF: mode <= 2'd0;
            32'h00900090: mode <= 2'd2;
            32'h00500050: begin sr_err <= 32'h0; op_err <= 32'h0; end
            32'h00200020: pend_e <= 1'b1;
            32'h00D000D0: if (pend_e) begin
              mem[bus_addr[3:0]] <= 32'hFFFFFFFF;
              busy_left <= busy_cfg; mode <= 2'd1; pend_e <= 1'b0; op_err <= err_cfg;
            end
            32'h00400040: pend_p <= 1'b1;
            32'h00700070: mode <= 2'd1;
            default: ;
          endcase
        end
      end
      if (bus_re) begin
        ra[rn % 2048] <= bus_addr;
        rn <= rn + 1;
        case (mode)
          2'd0: bus_rdata <= mem[bus_addr[3:0]];
          2'd2: bus_rdata <= (bus_addr == 0) ? mfr_val : ((bus_addr == 1) ? dev_val : 32'h0);
          default: begin
            if (busy_left > 0) begin
              bus_rdata <= busy_pat | sr_err;
              busy_left <= busy_left - 1;
            end else begin
              bus_rdata <= 32'h00800080 | sr_err | op_err;
            end
          end
        endcase
      end
    end
  end

  task automatic run_op(input logic [1:0] op, input logic [AW-1:0] addr, input logic [31:0] data,
                        input int lim, input int busy, input logic [31:0] pat,
                        input logic [31:0] err, input logic [31:0] flip, input logic [31:0] stale);
    int w0, r0, le, np, cyc, en, rexp;
    bit tmo;
    logic [1:0] er, got;
    logic [31:0] gm, gd;
    logic [31:0] ed [32];
    logic [AW-1:0] eaddr;
    string tag, rtag;
    @(negedge clk);
    busy_cfg = busy; busy_pat = pat; err_cfg = err; flip_cfg = flip; stale_cfg = stale;
    w0 = wn; r0 = rn;
    req_valid = 1'b1; req_op = op; req_addr = addr; req_data = data; poll_limit = lim[TW-1:0];
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R12 ready low while busy", {31'b0, req_ready}, 32'h0);
    cyc = 0;
    while (!rsp_valid && cyc < 500) begin @(negedge clk); cyc++; end
    chk(rsp_valid == 1'b1, "R12 response seen", {31'b0, rsp_valid}, 32'h1);
    got = rsp_result; gm = rsp_mfr; gd = rsp_dev;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R12 single-cycle response", {31'b0, rsp_valid}, 32'h0);

    le = (lim < 1) ? 1 : lim;
    tmo = (busy + 1) > le;
    np = tmo ? le : busy + 1;
    en = 0; rexp = 0; eaddr = addr; er = 2'd0;
    case (op)
      2'd0: begin
        tag = "R2 identify"; rtag = "R2 identify result";
        eaddr = '0; ed[0] = 32'h00900090; ed[1] = 32'h00FF00FF; en = 2; rexp = 2;
        chk(gm == mfr_val, "R2 manufacturer word", gm, mfr_val);
        chk(gd == dev_val, "R2 device word", gd, dev_val);
      end
      2'd3: begin tag = "R11 no-op"; rtag = "R11 no-op result"; end
      default: begin
        tag = (op == 2'd1) ? "R3 R5 R6 erase" : "R4 R5 R6 program";
        ed[0] = 32'h00500050;
        ed[1] = (op == 2'd1) ? 32'h00200020 : 32'h00400040;
        ed[2] = (op == 2'd1) ? 32'h00D000D0 : data;
        for (int i = 0; i < np; i++) ed[3 + i] = 32'h00700070;
        ed[3 + np] = 32'h00FF00FF;
        en = 4 + np;
        rexp = np + ((op == 2'd2 && !tmo) ? 1 : 0);
        if (tmo) begin er = 2'd3; rtag = "R9 timeout result"; end
        else if (op == 2'd1) begin
          er = ((err & 32'h00200020) != 0) ? 2'd1 : 2'd0;
          rtag = (busy + 1 == le) ? "R10 R7 erase result" : "R7 erase result";
        end else begin
          er = (((err & 32'h00100010) != 0) || flip != 0) ? 2'd2 : 2'd0;
          rtag = (busy + 1 == le) ? "R10 R8 program result" : "R8 program result";
        end
      end
    endcase
    chk(got == er, rtag, {30'b0, got}, {30'b0, er});
    chk(wn - w0 == en, {tag, " write count"}, wn - w0, en);
    if (wn - w0 == en)
      for (int i = 0; i < en; i++)
        chk(wd[(w0 + i) % 2048] == ed[i] && wa[(w0 + i) % 2048] == eaddr,
            {tag, " write sequence"}, wd[(w0 + i) % 2048], ed[i]);
    chk(rn - r0 == rexp, {tag, " read count"}, rn - r0, rexp);
    if (op == 2'd0 && rn - r0 == 2) begin
      chk(ra[r0 % 2048] == 0, "R2 first read word 0", {12'b0, ra[r0 % 2048]}, 32'h0);
      chk(ra[(r0 + 1) % 2048] == 1, "R2 second read word 1", {12'b0, ra[(r0 + 1) % 2048]}, 32'h1);
    end
    if ((op == 2'd1 || op == 2'd2) && rn - r0 == rexp)
      for (int i = 0; i < rexp; i++)
        chk(ra[(r0 + i) % 2048] == addr, {tag, " read address"}, {12'b0, ra[(r0 + i) % 2048]}, {12'b0, addr});
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog R12 actual=hung expected=response");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] pat, err, flip, stale;
    int unused_seed;
    unused_seed = $urandom(32'd7321);
    rst_n = 1'b0; req_valid = 1'b0; req_op = 2'd0; req_addr = '0; req_data = '0; poll_limit = '0;
    busy_cfg = 0; busy_pat = 0; err_cfg = 0; flip_cfg = 0; stale_cfg = 0;
    mfr_val = 32'h00890089; dev_val = 32'h88F488F4;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", {31'b0, req_ready}, 32'h1);
    chk(rsp_valid == 1'b0, "R1 no response after reset", {31'b0, rsp_valid}, 32'h0);
    chk(bus_we == 1'b0 && bus_re == 1'b0, "R1 bus quiet after reset", {30'b0, bus_we, bus_re}, 32'h0);
    chk(wn == 0 && rn == 0, "R1 no bus access after reset", wn + rn, 32'h0);

    run_op(2'd0, 20'h12345, 32'h0, 4, 0, 0, 0, 0, 0);
    dev_val = 32'h88F388F3;
    run_op(2'd0, 20'h00000, 32'h0, 4, 0, 0, 0, 0, 0);
    run_op(2'd3, 20'h00042, 32'h0, 4, 0, 0, 0, 0, 0);
    run_op(2'd1, 20'h00010, 32'h0, 3, 2, 32'h00000080, 0, 0, 0);
    run_op(2'd1, 20'h00011, 32'h0, 3, 3, 32'h00800000, 0, 0, 0);
    run_op(2'd1, 20'h00012, 32'h0, 0, 0, 0, 0, 0, 0);
    run_op(2'd1, 20'h00013, 32'h0, 5, 1, 0, 32'h00200000, 0, 0);
    run_op(2'd1, 20'h00014, 32'h0, 5, 1, 0, 0, 0, 32'h00200020);
    run_op(2'd2, 20'h00015, 32'hA5A5_5A5A, 6, 2, 32'h00000080, 0, 0, 0);
    run_op(2'd2, 20'h00016, 32'h1234_5678, 6, 0, 0, 0, 32'h0000_0100, 0);
    run_op(2'd2, 20'h00017, 32'hCAFE_F00D, 6, 1, 0, 32'h00100000, 0, 0);
    run_op(2'd2, 20'h00018, 32'hDEAD_BEEF, 6, 1, 0, 32'h00000010, 32'h8000_0000, 0);
    run_op(2'd2, 20'h00019, 32'h0F0F_0F0F, 2, 2, 0, 0, 0, 0);
    run_op(2'd2, 20'h0001A, 32'h0F0F_0F0F, 4, 1, 0, 0, 0, 32'h00100010);

    for (int n = 0; n < 40; n++) begin
      case ($urandom % 3)
        0: pat = 32'h0;
        1: pat = 32'h00000080;
        default: pat = 32'h00800000;
      endcase
      case ($urandom % 6)
        0: err = 32'h00000020;
        1: err = 32'h00200000;
        2: err = 32'h00000010;
        3: err = 32'h00100000;
        default: err = 32'h0;
      endcase
      flip = (($urandom % 4) == 0) ? ($urandom | 32'h1) : 32'h0;
      stale = (($urandom % 2) == 0) ? 32'h00300030 : 32'h0;
      run_op(2'(1 + ($urandom % 2)), AW'($urandom), $urandom,
             int'($urandom % 7), int'($urandom % 7), pat, err, flip, stale);
    end

    chk(both_cnt == 0, "R13 no cycle with read and write", both_cnt, 32'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule